// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Unit

This block is a packed signed-integer arithmetic step for a vector datapath. Each accepted request takes an accumulator vector, a first source vector and a second source vector. Every active lane multiplies its two signed source elements. The full-precision product is doubled and then added to, or subtracted from, the accumulator element placed in the upper half of a double-width value. A rounding constant is added. The high half is kept and clamped to the signed element range. The second source can supply a lane per lane, or a single broadcast element picked by an index. A scalar form computes only the lowest element.

The unit accepts one request per cycle and returns the result one cycle later, marked by `out_valid`. A sticky saturation flag records any clamping since it was last cleared. It is cleared by reset or by a synchronous clear input.

Top module: `sqrdmac_unit`

## Requirements
- R1: With `op_sub`=0, `elem32`=0, `mode`=2'b00 and `wide`=1, lane i (bits [16i+15:16i], i=0..7) becomes sat16(((acc<<16) + 2·a·b + 0x8000) >>> 16). All terms are signed and the intermediate is exact.
- R2: With `op_sub`=1, the doubled product is subtracted instead: sat(((acc<<E) − 2·a·b + 2^(E−1)) >>> E), where E is the element width.
- R3: A lane whose shifted value lies outside the signed E-bit range gives 0x7FFF/0x8000 (16-bit) or 0x7FFFFFFF/0x80000000 (32-bit). This includes a product of two most-negative values.
- R4: With `elem32`=1, the same arithmetic runs on 32-bit lanes at bits [32i+31:32i] (four lanes at 128-bit width).
- R5: With `mode`=2'b00 or 2'b01 and `wide`=0, only the lanes in bits [63:0] are computed, and `result[127:64]` is zero.
- R6: With `mode`=2'b01 (by-element), every lane uses the one `src_b` element chosen by `lane_idx`. The index is masked to 3 bits (16-bit, `src_wide`=1), 2 bits (16-bit, `src_wide`=0), 2 bits (32-bit, `src_wide`=1) or 1 bit (32-bit, `src_wide`=0).
- R7: With `mode`=2'b10 (scalar, second operand in `src_b` element 0) or 2'b11 (scalar, second operand chosen as in R6), only element 0 is computed, and every result bit above it is zero.
- R8: `sat_flag` rises in the cycle the result of a saturating request appears. It then stays high through later non-saturating requests.
- R9: `sat_clr`=1 clears `sat_flag` at the next edge. If a request in that same cycle saturates, the flag is set instead.
- R10: `out_valid` equals `in_valid` delayed by one cycle, and `result` holds its value in cycles without a request.
- R11: After reset, `out_valid`, `result` and `sat_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 0 accumulate, 1 subtract |
| elem32 | input | 1 | 0 16-bit lanes, 1 32-bit lanes |
| wide | input | 1 | 0 64-bit vectors, 1 128-bit vectors |
| mode | input | 2 | 00 vector, 01 by-element, 10 scalar, 11 scalar by-element |
| src_wide | input | 1 | Width of the second source for index masking: 0 64-bit, 1 128-bit |
| lane_idx | input | 3 | Broadcast element index |
| acc_in | input | 128 | Accumulator vector |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| sat_clr | input | 1 | Synchronous clear of the saturation flag |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Result vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Hand-worked scalar operands separate several error classes. Exact rounding on the 0x4000/0x3FFF boundary catches a missing or misplaced rounding constant. Most-negative squared operands catch a saturated product or a wrong doubling. Sums near both range ends catch a clamp that is wrong in one direction. Dense mixed-sign 128-bit vectors, in both sizes, widths and signs of operation, show whether lane slicing and per-lane sign handling are right. By-element requests with indices above the legal range show whether the index is masked according to element size and second-source width. Back-to-back requests with and without the clear input tell the sticky behaviour apart from a per-request flag.

// File: rtl/sqrdmac_unit.sv
module sqrdmac_unit #(
  parameter int VEC_W = 128,
  parameter int H_W   = 16,
  parameter int IDX_W = $clog2(VEC_W / H_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             elem32,
  input  logic             wide,
  input  logic [1:0]       mode,
  input  logic             src_wide,
  input  logic [IDX_W-1:0] lane_idx,
  input  logic [VEC_W-1:0] acc_in,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag
);
  logic             by_elem, scalar;
  logic [VEC_W-1:0] res_sz [2];
  logic [1:0]       sat_sz;

  assign by_elem = mode[0];
  assign scalar  = mode[1];

  for (genvar s = 0; s < 2; s++) begin : g_sz
    localparam int E  = H_W << s;
    localparam int N  = VEC_W / E;
    localparam int IW = $clog2(N);
    localparam int W  = 2 * E + 2;
    localparam logic signed [W-1:0] RND = W'(1) << (E - 1);
    localparam logic [E-1:0] MAXV = {1'b0, {(E-1){1'b1}}};
    localparam logic [E-1:0] MINV = {1'b1, {(E-1){1'b0}}};

    logic [IW-1:0] idx;
    logic [E-1:0]  bcast;
    logic [N-1:0]  lane_sat;

    assign idx   = src_wide ? lane_idx[IW-1:0] : {1'b0, lane_idx[IW-2:0]};
    assign bcast = src_b[idx*E +: E];

    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [E-1:0]          av, bv, cv;
      logic signed [W-1:0]   ax, bx, cx, dbl, t;
      logic signed [E+1:0]   hi;
      logic                  ovf, act;
      logic                  unused_lo;

      assign av  = src_a[i*E +: E];
      assign cv  = acc_in[i*E +: E];
      assign bv  = by_elem ? bcast : src_b[i*E +: E];
      assign ax  = {{(W-E){av[E-1]}}, av};
      assign bx  = {{(W-E){bv[E-1]}}, bv};
      assign cx  = {{2{cv[E-1]}}, cv, {E{1'b0}}};
      assign dbl = (ax * bx) <<< 1;
      assign t   = (op_sub ? cx - dbl : cx + dbl) + RND;
      assign hi  = t[W-1:E];
      assign unused_lo = ^t[E-1:0];
      assign ovf = !(hi[E+1:E-1] == 3'b000 || hi[E+1:E-1] == 3'b111);
      assign act = scalar ? (i == 0) : (wide || i < N / 2);
      assign lane_sat[i] = act && ovf;
      assign res_sz[s][i*E +: E] = !act ? '0 :
                                   ovf  ? (hi[E+1] ? MINV : MAXV) :
                                          hi[E-1:0];
    end

    assign sat_sz[s] = |lane_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_sz[elem32];
      sat_flag <= (sat_flag && !sat_clr) || (in_valid && sat_sz[elem32]);
    end
  end
endmodule

// File: rtl/sqrdmac_unit_chk.sv
module sqrdmac_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             elem32,
  input logic             wide,
  input logic [1:0]       mode,
  input logic             sat_clr,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             sat_flag
);
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide && !mode[1]) |=> result[VEC_W-1:VEC_W/2] == '0);
  assert_scalar16_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && !elem32) |=> result[VEC_W-1:16] == '0);
  assert_scalar32_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && elem32) |=> result[VEC_W-1:32] == '0);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  assert_flag_rise_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_flag |=> (!sat_flag || $past(in_valid)));
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !in_valid) |=> !sat_flag);
endmodule

bind sqrdmac_unit sqrdmac_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem32(elem32), .wide(wide),
  .mode(mode), .sat_clr(sat_clr), .out_valid(out_valid), .result(result),
  .sat_flag(sat_flag)
);

// File: tb/sqrdmac_unit_tb.sv
module sqrdmac_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, op_sub = 1'b0, elem32 = 1'b0, wide = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic         src_wide = 1'b1;
  logic [2:0]   lane_idx = '0;
  logic [127:0] acc_in = '0, src_a = '0, src_b = '0;
  logic         sat_clr = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_flag;
  int           checks = 0, failures = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  sqrdmac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub), .elem32(elem32),
    .wide(wide), .mode(mode), .src_wide(src_wide), .lane_idx(lane_idx),
    .acc_in(acc_in), .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  // {op_sub, elem32, acc[31:0], a[31:0], b[31:0], expected[31:0], expected_sat}
  localparam int NROWS = 10;
  localparam logic [130:0] TAB [NROWS] = '{
    {1'b0, 1'b0, 32'h0000_0100, 32'h0000_4000, 32'h0000_4000, 32'h0000_2100, 1'b0},
    {1'b0, 1'b0, 32'h0000_7000, 32'h0000_4000, 32'h0000_4000, 32'h0000_7FFF, 1'b1},
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_8000, 32'h0000_8000, 32'h0000_7FFF, 1'b1},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_8000, 32'h0000_8000, 32'h0000_8000, 1'b0},
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001, 32'h0000_4000, 32'h0000_0001, 1'b0},
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001, 32'h0000_3FFF, 32'h0000_0000, 1'b0},
    {1'b1, 1'b0, 32'h0000_8000, 32'h0000_4000, 32'h0000_4000, 32'h0000_8000, 1'b1},
    {1'b0, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0},
    {1'b0, 1'b1, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1},
    {1'b1, 1'b1, 32'h0000_0010, 32'h0000_0000, 32'h0000_0005, 32'h0000_0010, 1'b0}
  };

  localparam logic [127:0] PA = 128'h8000_7FFF_1234_C000_0001_FFFF_4000_8000;
  localparam logic [127:0] PB = 128'h8000_7FFF_5678_4000_4000_FFFF_C000_0001;
  localparam logic [127:0] PC = 128'h0000_7FFF_ABCD_8000_0000_0001_2000_FFFF;

  function automatic logic [128:0] ref_mac(input logic sub, input logic e32,
      input logic wd, input logic [1:0] md, input logic sw, input logic [2:0] idx,
      input logic [127:0] c, input logic [127:0] a, input logic [127:0] b);
    int e, n, act, bi, k2;
    logic signed [67:0] x, y, z, t, mx, mn;
    logic [127:0] r;
    logic s;
    e   = e32 ? 32 : 16;
    n   = 128 / e;
    act = md[1] ? 1 : (wd ? n : n / 2);
    bi  = e32 ? (sw ? idx % 4 : idx % 2) : (sw ? idx % 8 : idx % 4);
    mx  = e32 ? 68'sh7FFF_FFFF : 68'sh7FFF;
    mn  = -mx - 68'sd1;
    r = '0;
    s = 1'b0;
    for (int k = 0; k < act; k++) begin
      k2 = md[0] ? bi : k;
      if (e32) begin
        x = 68'($signed(c[k*32 +: 32]));
        y = 68'($signed(a[k*32 +: 32]));
        z = 68'($signed(b[k2*32 +: 32]));
      end else begin
        x = 68'($signed(c[k*16 +: 16]));
        y = 68'($signed(a[k*16 +: 16]));
        z = 68'($signed(b[k2*16 +: 16]));
      end
      t = sub ? (x <<< e) - 68'sd2 * y * z : (x <<< e) + 68'sd2 * y * z;
      t = (t + (68'sd1 <<< (e - 1))) >>> e;
      if (t > mx) begin t = mx; s = 1'b1; end
      else if (t < mn) begin t = mn; s = 1'b1; end
      if (e32) r[k*32 +: 32] = t[31:0];
      else     r[k*16 +: 16] = t[15:0];
    end
    return {s, r};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic sub, input logic e32, input logic wd, input logic [1:0] md,
                       input logic sw, input logic [2:0] idx, input logic [127:0] c,
                       input logic [127:0] a, input logic [127:0] b, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; elem32 = e32; wide = wd; mode = md;
    src_wide = sw; lane_idx = idx; acc_in = c; src_a = a; src_b = b; sat_clr = clr;
    @(posedge clk);
    #1;
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  task automatic vec_case(input string req, input logic sub, input logic e32, input logic wd,
                          input logic [1:0] md, input logic sw, input logic [2:0] idx);
    logic [128:0] exp;
    exp = ref_mac(sub, e32, wd, md, sw, idx, PC, PA, PB);
    issue(sub, e32, wd, md, sw, idx, PC, PA, PB, 1'b1);
    check(req, result, exp[127:0]);
    check({req, " flag"}, {127'b0, sat_flag}, {127'b0, exp[128]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R11 out_valid", {127'b0, out_valid}, '0);
    check("R11 result", result, '0);
    check("R11 sat_flag", {127'b0, sat_flag}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Scalar rows: R1 R2 R3 R4 R7 R9 (clear in same cycle, flag follows the row)
    for (int i = 0; i < NROWS; i++) begin
      logic [130:0] row;
      row = TAB[i];
      issue(row[130], row[129], 1'b1, 2'b10, 1'b1, 3'd0,
            {96'hDEAD_BEEF_0123_4567_89AB_CDEF, row[128:97]},
            {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, row[96:65]},
            {96'h5555_AAAA_5555_AAAA_5555_AAAA, row[64:33]}, 1'b1);
      check($sformatf("R7 R3 scalar row %0d valid", i), {127'b0, out_valid}, 128'd1);
      check($sformatf("R1 R2 R3 R4 R7 scalar row %0d", i), result, {96'b0, row[32:1]});
      check($sformatf("R9 R3 scalar row %0d flag", i), {127'b0, sat_flag}, {127'b0, row[0]});
    end

    vec_case("R1 vec16 add", 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 3'd0);
    vec_case("R2 vec16 sub", 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 3'd0);
    vec_case("R4 vec32 add", 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 3'd0);
    vec_case("R4 R2 vec32 sub", 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 3'd0);
    vec_case("R5 vec16 narrow", 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 3'd0);
    vec_case("R5 vec32 narrow", 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 3'd0);
    vec_case("R6 elem16 idx5", 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 3'd5);
    vec_case("R6 elem16 idx6 masked", 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 3'd6);
    vec_case("R6 elem32 idx3 masked", 1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 3'd3);
    vec_case("R6 elem32 idx6 masked", 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 3'd6);
    vec_case("R7 scalar16 by-element", 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 3'd7);
    vec_case("R7 scalar32 by-element", 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 3'd1);

    // R8: sticky across a later clean request
    issue(1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 3'd0, '0, 128'h8000, 128'h8000, 1'b1);
    check("R8 set", {127'b0, sat_flag}, 128'd1);
    issue(1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 3'd0, 128'h0100, 128'h4000, 128'h4000, 1'b0);
    check("R8 held result", result, 128'h2100);
    check("R8 held flag", {127'b0, sat_flag}, 128'd1);

    // R10: hold with no request
    held = result;
    repeat (2) @(posedge clk);
    #1;
    check("R10 out_valid low", {127'b0, out_valid}, '0);
    check("R10 result held", result, held);
    check("R10 flag unchanged", {127'b0, sat_flag}, 128'd1);

    // R9: clear without a request
    @(negedge clk);
    sat_clr = 1'b1;
    @(posedge clk);
    #1;
    sat_clr = 1'b0;
    check("R9 cleared", {127'b0, sat_flag}, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule